// File: doc/BRIEF.md
# Packed Integer Add/Subtract/Compare ALU

This block is a single-stage SIMD integer unit for a 64-bit datapath. Each operation treats two 64-bit operands as a set of independent lanes: eight bytes, four words, two doublewords or one quadword, as chosen by a lane-size select. The unit covers lane-wise addition and subtraction under three overflow policies, equality and signed greater-than comparisons that yield lane masks, per-lane logical and arithmetic shifts, and four full-width bitwise functions.

The datapath itself is combinational. Its result is captured in an output register when the input valid is high, and the output valid strobe follows one clock later. A combination of operation and lane size that the unit does not support raises an illegal flag and returns zero instead of a result. A pipeline controller issues one operation per cycle and takes the result on the strobe.

Top module: `packed_int_alu`

## Requirements
- R1: Lane select encoding is 0 = byte, 1 = word, 2 = doubleword, 3 = quadword. Wraparound add (op 0) and subtract (op 3) work on byte, word and doubleword lanes, keep only the low bits of each lane, and pass no carry or borrow into the next lane.
- R2: Signed-saturating add (op 1) and subtract (op 4) on byte and word lanes clamp an overflowing lane to its most positive or most negative two's-complement value.
- R3: Unsigned-saturating add (op 2) clamps an overflowing lane to all ones. Unsigned-saturating subtract (op 5) clamps an underflowing lane to zero. Both work on byte and word lanes.
- R4: Compare-equal (op 6) and signed compare-greater (op 7, first operand greater than second) write all ones into a lane where the condition holds and all zeros elsewhere, on byte, word and doubleword lanes.
- R5: Left shift (op 8) and logical right shift (op 9) work on word, doubleword and quadword lanes. The count is the whole second operand taken as unsigned. Vacated bits are zero, and a count equal to or above the lane width gives a zero lane.
- R6: Arithmetic right shift (op 10) works on word and doubleword lanes, copies each lane's top bit into the vacated bits, and with a count equal to or above the lane width fills the lane with its sign.
- R7: AND (op 11), AND-NOT (op 12, inverted first operand ANDed with the second), OR (op 13) and XOR (op 14) act on all 64 bits for every lane select.
- R8: Every unsupported pairing of op and lane select, and op 15, sets the illegal flag and returns a zero result; supported pairings clear the flag.
- R9: The output valid equals the input valid of the previous cycle. Result and illegal flag load only in a cycle with input valid high and hold otherwise.
- R10: A synchronous reset clears the output valid, the result and the illegal flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation request for this cycle |
| op_code | input | 4 | Operation select |
| lane_sel | input | 2 | Lane size select |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand, or shift count |
| res_data | output | 64 | Registered result |
| res_valid | output | 1 | Result strobe, one cycle after in_valid |
| res_illegal | output | 1 | Registered unsupported-operation flag |

## Verification
The assertions take for granted that op_code, lane_sel and both operands are known, non-X values in every cycle where in_valid is high, and that reset is held from time zero until the first clock edge. The stimulus changes inputs only on the falling clock edge, keeps every field driven to a defined value even while in_valid is low, and covers each supported pairing of op and lane select as well as several unsupported ones, so the mask and illegal-result properties see both their outcomes.

// File: rtl/packed_int_alu_pkg.sv
package packed_int_alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD_WRAP = 4'd0,
      OP_ADD_SSAT = 4'd1,
      OP_ADD_USAT = 4'd2,
      OP_SUB_WRAP = 4'd3,
      OP_SUB_SSAT = 4'd4,
      OP_SUB_USAT = 4'd5,
      OP_CMP_EQ   = 4'd6,
      OP_CMP_GT   = 4'd7,
      OP_SHL      = 4'd8,
      OP_SHR_L    = 4'd9,
      OP_SHR_A    = 4'd10,
      OP_AND      = 4'd11,
      OP_ANDN     = 4'd12,
      OP_OR       = 4'd13,
      OP_XOR      = 4'd14,
      OP_RSVD     = 4'd15
   } alu_op_e;

   typedef enum logic [1:0] {
      LS_BYTE = 2'd0,
      LS_WORD = 2'd1,
      LS_DWRD = 2'd2,
      LS_QWRD = 2'd3
   } lane_sz_e;

   localparam int NUM_SIZES = 4;

   // Supported pairings of operation and lane size
   function automatic logic op_is_legal(alu_op_e op, lane_sz_e ls);
      logic ok;
      case (op)
         OP_ADD_WRAP, OP_SUB_WRAP,
         OP_CMP_EQ,   OP_CMP_GT:   ok = (ls != LS_QWRD);
         OP_ADD_SSAT, OP_ADD_USAT,
         OP_SUB_SSAT, OP_SUB_USAT: ok = (ls == LS_BYTE) || (ls == LS_WORD);
         OP_SHL, OP_SHR_L:         ok = (ls != LS_BYTE);
         OP_SHR_A:                 ok = (ls == LS_WORD) || (ls == LS_DWRD);
         OP_AND, OP_ANDN,
         OP_OR,  OP_XOR:           ok = 1'b1;
         default:                  ok = 1'b0;
      endcase
      return ok;
   endfunction

endpackage

// File: rtl/simd_lane_addsub.sv
module simd_lane_addsub #(
   parameter int DATA_W = 64,
   parameter int LANE_W = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] add_wrap,
   output logic [DATA_W-1:0] add_ssat,
   output logic [DATA_W-1:0] add_usat,
   output logic [DATA_W-1:0] sub_wrap,
   output logic [DATA_W-1:0] sub_ssat,
   output logic [DATA_W-1:0] sub_usat
);

   localparam int N_LANES = DATA_W / LANE_W;
   localparam logic [LANE_W-1:0] S_MAX = {1'b0, {(LANE_W-1){1'b1}}};
   localparam logic [LANE_W-1:0] S_MIN = {1'b1, {(LANE_W-1){1'b0}}};

   for (genvar i = 0; i < N_LANES; i++) begin : g_lane
      logic [LANE_W-1:0] la, lb;
      logic [LANE_W:0]   sum, dif;
      logic              add_ovf, sub_ovf;

      assign la  = a[i*LANE_W +: LANE_W];
      assign lb  = b[i*LANE_W +: LANE_W];
      assign sum = {1'b0, la} + {1'b0, lb};
      assign dif = {1'b0, la} - {1'b0, lb};

      // Signed overflow: operands of equal sign, result sign differs
      assign add_ovf = (la[LANE_W-1] == lb[LANE_W-1]) && (sum[LANE_W-1] != la[LANE_W-1]);
      // Signed overflow: operands of opposite sign, result sign differs from a
      assign sub_ovf = (la[LANE_W-1] != lb[LANE_W-1]) && (dif[LANE_W-1] != la[LANE_W-1]);

      assign add_wrap[i*LANE_W +: LANE_W] = sum[LANE_W-1:0];
      assign sub_wrap[i*LANE_W +: LANE_W] = dif[LANE_W-1:0];
      assign add_ssat[i*LANE_W +: LANE_W] = add_ovf ? (la[LANE_W-1] ? S_MIN : S_MAX) : sum[LANE_W-1:0];
      assign sub_ssat[i*LANE_W +: LANE_W] = sub_ovf ? (la[LANE_W-1] ? S_MIN : S_MAX) : dif[LANE_W-1:0];
      assign add_usat[i*LANE_W +: LANE_W] = sum[LANE_W] ? {LANE_W{1'b1}} : sum[LANE_W-1:0];
      assign sub_usat[i*LANE_W +: LANE_W] = dif[LANE_W] ? {LANE_W{1'b0}} : dif[LANE_W-1:0];
   end

endmodule

// File: rtl/simd_lane_cmp.sv
module simd_lane_cmp #(
   parameter int DATA_W = 64,
   parameter int LANE_W = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] eq_mask,
   output logic [DATA_W-1:0] gt_mask
);

   localparam int N_LANES = DATA_W / LANE_W;

   for (genvar i = 0; i < N_LANES; i++) begin : g_lane
      logic signed [LANE_W-1:0] la, lb;
      assign la = a[i*LANE_W +: LANE_W];
      assign lb = b[i*LANE_W +: LANE_W];
      assign eq_mask[i*LANE_W +: LANE_W] = {LANE_W{la == lb}};
      assign gt_mask[i*LANE_W +: LANE_W] = {LANE_W{la > lb}};
   end

endmodule

// File: rtl/simd_lane_shift.sv
module simd_lane_shift #(
   parameter int DATA_W = 64,
   parameter int LANE_W = 16
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] cnt,
   output logic [DATA_W-1:0] shl,
   output logic [DATA_W-1:0] shr_l,
   output logic [DATA_W-1:0] shr_a
);

   localparam int N_LANES = DATA_W / LANE_W;
   localparam int SH_W    = $clog2(LANE_W);

   logic              over;
   logic [SH_W-1:0]   amt;

   // One count for all lanes; anything at or past the lane width saturates
   assign over = (cnt >= DATA_W'(LANE_W));
   assign amt  = cnt[SH_W-1:0];

   for (genvar i = 0; i < N_LANES; i++) begin : g_lane
      logic        [LANE_W-1:0] la;
      logic signed [LANE_W-1:0] las;
      assign la  = a[i*LANE_W +: LANE_W];
      assign las = la;
      assign shl  [i*LANE_W +: LANE_W] = over ? '0 : (la << amt);
      assign shr_l[i*LANE_W +: LANE_W] = over ? '0 : (la >> amt);
      assign shr_a[i*LANE_W +: LANE_W] = over ? {LANE_W{la[LANE_W-1]}} : LANE_W'(las >>> amt);
   end

endmodule

// File: rtl/packed_int_alu.sv
module packed_int_alu
   import packed_int_alu_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [3:0]        op_code,
   input  logic [1:0]        lane_sel,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   output logic [DATA_W-1:0] res_data,
   output logic              res_valid,
   output logic              res_illegal
);

   localparam int MIN_LANE = 8;
   localparam int MAX_LANE = MIN_LANE << (NUM_SIZES - 1);

   if (DATA_W % MAX_LANE != 0 || DATA_W < MAX_LANE) begin : g_bad_width
      $error("packed_int_alu: DATA_W must be a positive multiple of %0d", MAX_LANE);
   end

   logic [DATA_W-1:0] v_add_wrap [NUM_SIZES];
   logic [DATA_W-1:0] v_add_ssat [NUM_SIZES];
   logic [DATA_W-1:0] v_add_usat [NUM_SIZES];
   logic [DATA_W-1:0] v_sub_wrap [NUM_SIZES];
   logic [DATA_W-1:0] v_sub_ssat [NUM_SIZES];
   logic [DATA_W-1:0] v_sub_usat [NUM_SIZES];
   logic [DATA_W-1:0] v_eq       [NUM_SIZES];
   logic [DATA_W-1:0] v_gt       [NUM_SIZES];
   logic [DATA_W-1:0] v_shl      [NUM_SIZES];
   logic [DATA_W-1:0] v_shr_l    [NUM_SIZES];
   logic [DATA_W-1:0] v_shr_a    [NUM_SIZES];

   // One lane engine per lane size, all working in parallel
   for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
      localparam int LW = MIN_LANE << g;

      simd_lane_addsub #(.DATA_W(DATA_W), .LANE_W(LW)) u_addsub (
         .a        (opnd_a),
         .b        (opnd_b),
         .add_wrap (v_add_wrap[g]),
         .add_ssat (v_add_ssat[g]),
         .add_usat (v_add_usat[g]),
         .sub_wrap (v_sub_wrap[g]),
         .sub_ssat (v_sub_ssat[g]),
         .sub_usat (v_sub_usat[g])
      );

      simd_lane_cmp #(.DATA_W(DATA_W), .LANE_W(LW)) u_cmp (
         .a       (opnd_a),
         .b       (opnd_b),
         .eq_mask (v_eq[g]),
         .gt_mask (v_gt[g])
      );

      simd_lane_shift #(.DATA_W(DATA_W), .LANE_W(LW)) u_shift (
         .a     (opnd_a),
         .cnt   (opnd_b),
         .shl   (v_shl[g]),
         .shr_l (v_shr_l[g]),
         .shr_a (v_shr_a[g])
      );
   end

   alu_op_e           op;
   lane_sz_e          ls;
   logic              legal;
   logic [DATA_W-1:0] nxt_data;

   assign op    = alu_op_e'(op_code);
   assign ls    = lane_sz_e'(lane_sel);
   assign legal = op_is_legal(op, ls);

   always_comb begin
      nxt_data = '0;
      if (legal) begin
         case (op)
            OP_ADD_WRAP: nxt_data = v_add_wrap[ls];
            OP_ADD_SSAT: nxt_data = v_add_ssat[ls];
            OP_ADD_USAT: nxt_data = v_add_usat[ls];
            OP_SUB_WRAP: nxt_data = v_sub_wrap[ls];
            OP_SUB_SSAT: nxt_data = v_sub_ssat[ls];
            OP_SUB_USAT: nxt_data = v_sub_usat[ls];
            OP_CMP_EQ:   nxt_data = v_eq[ls];
            OP_CMP_GT:   nxt_data = v_gt[ls];
            OP_SHL:      nxt_data = v_shl[ls];
            OP_SHR_L:    nxt_data = v_shr_l[ls];
            OP_SHR_A:    nxt_data = v_shr_a[ls];
            OP_AND:      nxt_data = opnd_a & opnd_b;
            OP_ANDN:     nxt_data = ~opnd_a & opnd_b;
            OP_OR:       nxt_data = opnd_a | opnd_b;
            OP_XOR:      nxt_data = opnd_a ^ opnd_b;
            default:     nxt_data = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         res_valid   <= 1'b0;
         res_data    <= '0;
         res_illegal <= 1'b0;
      end else begin
         res_valid <= in_valid;
         if (in_valid) begin
            res_data    <= nxt_data;
            res_illegal <= ~legal;
         end
      end
   end

endmodule

// File: rtl/packed_int_alu_chk.sv
module packed_int_alu_chk
   import packed_int_alu_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [3:0]        op_code,
   input logic [1:0]        lane_sel,
   input logic [DATA_W-1:0] opnd_a,
   input logic [DATA_W-1:0] opnd_b,
   input logic [DATA_W-1:0] res_data,
   input logic              res_valid,
   input logic              res_illegal
);

   // Every byte lane is uniformly all ones or all zeros
   function automatic logic bytes_uniform(logic [DATA_W-1:0] d);
      logic ok = 1'b1;
      for (int i = 0; i < DATA_W / 8; i++) begin
         if (d[i*8 +: 8] != 8'h00 && d[i*8 +: 8] != 8'hFF) ok = 1'b0;
      end
      return ok;
   endfunction

   p_valid_rise_r9: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> res_valid);

   p_valid_fall_r9: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !res_valid);

   p_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(res_data) && $stable(res_illegal)));

   p_illegal_zero_r8: assert property (@(posedge clk) disable iff (rst)
      res_illegal |-> (res_data == '0));

   p_byte_mask_r4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && (op_code == OP_CMP_EQ || op_code == OP_CMP_GT) && lane_sel == LS_BYTE)
      |=> bytes_uniform(res_data));

   p_eq_self_r4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op_code == OP_CMP_EQ && lane_sel != LS_QWRD && opnd_a == opnd_b)
      |=> (res_data == '1));

   p_xor_full_r7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op_code == OP_XOR)
      |=> (res_data == $past(opnd_a ^ opnd_b) && !res_illegal));

   p_reset_clear_r10: assert property (@(posedge clk)
      rst |=> (!res_valid && !res_illegal && res_data == '0));

endmodule

bind packed_int_alu packed_int_alu_chk #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .in_valid    (in_valid),
   .op_code     (op_code),
   .lane_sel    (lane_sel),
   .opnd_a      (opnd_a),
   .opnd_b      (opnd_b),
   .res_data    (res_data),
   .res_valid   (res_valid),
   .res_illegal (res_illegal)
);

// File: tb/packed_int_alu_test.sv
module packed_int_alu_test;

   typedef struct packed {
      logic [3:0]  op;
      logic [1:0]  ls;
      logic [63:0] a;
      logic [63:0] b;
      logic [63:0] exp;
      logic        ill;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 27;

   // Columns: op, lane, a, b, expected, illegal, requirement number
   localparam vec_t VECS [NV] = '{
      // R1 wraparound, carry must not leave byte 0
      '{4'd0, 2'd0, 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000, 1'b0, 4'd1},
      // R1 word wraparound
      '{4'd0, 2'd1, 64'h7FFF_0001_FFFF_1234, 64'h0001_0001_0001_0001, 64'h8000_0002_0000_1235, 1'b0, 4'd1},
      // R1 doubleword borrow dropped
      '{4'd3, 2'd2, 64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 4'd1},
      // R2 signed saturating byte add
      '{4'd1, 2'd0, 64'h7F80_0102_0000_0000, 64'h01FF_7FFE_0000_0000, 64'h7F80_7F00_0000_0000, 1'b0, 4'd2},
      // R2 signed saturating word subtract
      '{4'd4, 2'd1, 64'h8000_7FFF_0005_0000, 64'h0001_FFFF_0007_8000, 64'h8000_7FFF_FFFE_7FFF, 1'b0, 4'd2},
      // R3 unsigned saturating byte add
      '{4'd2, 2'd0, 64'hFF80_1000_0000_00F0, 64'h0180_2000_0000_0020, 64'hFFFF_3000_0000_00FF, 1'b0, 4'd3},
      // R3 unsigned saturating word subtract
      '{4'd5, 2'd1, 64'h0005_1000_0000_FFFF, 64'h0006_0FFF_0001_0001, 64'h0000_0001_0000_FFFE, 1'b0, 4'd3},
      // R4 byte equality mask
      '{4'd6, 2'd0, 64'h1122_3344_5566_7788, 64'h1100_3300_5500_7700, 64'hFF00_FF00_FF00_FF00, 1'b0, 4'd4},
      // R4 signed word greater-than
      '{4'd7, 2'd1, 64'h0001_8000_7FFF_0005, 64'h0000_0001_8000_0005, 64'hFFFF_0000_FFFF_0000, 1'b0, 4'd4},
      // R4 signed doubleword greater-than
      '{4'd7, 2'd2, 64'hFFFF_FFFF_0000_0002, 64'h0000_0000_0000_0001, 64'h0000_0000_FFFF_FFFF, 1'b0, 4'd4},
      // R5 word left shift by 4
      '{4'd8, 2'd1, 64'h1234_8001_00FF_FFFF, 64'd4, 64'h2340_0010_0FF0_FFF0, 1'b0, 4'd5},
      // R5 doubleword logical right by 8
      '{4'd9, 2'd2, 64'h8000_0000_1234_5678, 64'd8, 64'h0080_0000_0012_3456, 1'b0, 4'd5},
      // R5 quadword left by 4
      '{4'd8, 2'd3, 64'h8123_4567_89AB_CDEF, 64'd4, 64'h1234_5678_9ABC_DEF0, 1'b0, 4'd5},
      // R5 quadword count equal to width
      '{4'd8, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd64, 64'h0000_0000_0000_0000, 1'b0, 4'd5},
      // R5 word logical right count equal to width
      '{4'd9, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd16, 64'h0000_0000_0000_0000, 1'b0, 4'd5},
      // R6 word arithmetic right by 4
      '{4'd10, 2'd1, 64'h8000_7FF0_F00F_0010, 64'd4, 64'hF800_07FF_FF00_0001, 1'b0, 4'd6},
      // R6 doubleword arithmetic right past width
      '{4'd10, 2'd2, 64'h8000_0000_7FFF_FFFF, 64'd40, 64'hFFFF_FFFF_0000_0000, 1'b0, 4'd6},
      // R7 AND-NOT inverts the first operand
      '{4'd12, 2'd0, 64'hFF00_FF00_F0F0_0000, 64'hFFFF_0000_FFFF_1234, 64'h00FF_0000_0F0F_1234, 1'b0, 4'd7},
      // R7 XOR
      '{4'd14, 2'd2, 64'hAAAA_AAAA_5555_5555, 64'hFFFF_0000_FFFF_0000, 64'h5555_AAAA_AAAA_5555, 1'b0, 4'd7},
      // R7 AND
      '{4'd11, 2'd1, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 64'hF000_F000_F000_F000, 1'b0, 4'd7},
      // R7 OR with quadword select
      '{4'd13, 2'd3, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 64'hFFF0_FFF0_FFF0_FFF0, 1'b0, 4'd7},
      // R8 signed saturation on doublewords
      '{4'd1, 2'd2, 64'h0000_0001_0000_0001, 64'h0000_0001_0000_0001, 64'h0, 1'b1, 4'd8},
      // R8 arithmetic shift on bytes
      '{4'd10, 2'd0, 64'h8080_8080_8080_8080, 64'd1, 64'h0, 1'b1, 4'd8},
      // R8 left shift on bytes
      '{4'd8, 2'd0, 64'h0101_0101_0101_0101, 64'd1, 64'h0, 1'b1, 4'd8},
      // R8 reserved op code
      '{4'd15, 2'd1, 64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, 64'h0, 1'b1, 4'd8},
      // R8 wraparound add on quadword
      '{4'd0, 2'd3, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, 64'h0, 1'b1, 4'd8},
      // R8 compare on quadword
      '{4'd6, 2'd3, 64'h5555_5555_5555_5555, 64'h5555_5555_5555_5555, 64'h0, 1'b1, 4'd8}
   };

   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [3:0]  op_code;
   logic [1:0]  lane_sel;
   logic [63:0] opnd_a;
   logic [63:0] opnd_b;
   logic [63:0] res_data;
   logic        res_valid;
   logic        res_illegal;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   packed_int_alu uut (
      .clk         (clk),
      .rst         (rst),
      .in_valid    (in_valid),
      .op_code     (op_code),
      .lane_sel    (lane_sel),
      .opnd_a      (opnd_a),
      .opnd_b      (opnd_b),
      .res_data    (res_data),
      .res_valid   (res_valid),
      .res_illegal (res_illegal)
   );

   task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Drive one request on a falling edge, sample one full cycle later
   task automatic issue(logic [3:0] op, logic [1:0] ls, logic [63:0] a, logic [63:0] b);
      @(negedge clk);
      op_code  = op;
      lane_sel = ls;
      opnd_a   = a;
      opnd_b   = b;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      rst      = 1'b1;
      in_valid = 1'b0;
      op_code  = 4'd0;
      lane_sel = 2'd0;
      opnd_a   = '0;
      opnd_b   = '0;
      repeat (3) @(negedge clk);
      // R10 state after reset
      check64("R10 valid", {63'b0, res_valid}, 64'd0);
      check64("R10 data", res_data, 64'd0);
      check64("R10 illegal", {63'b0, res_illegal}, 64'd0);
      rst = 1'b0;

      for (int k = 0; k < NV; k++) begin
         string tag;
         tag = $sformatf("R%0d vec%0d", VECS[k].req, k);
         issue(VECS[k].op, VECS[k].ls, VECS[k].a, VECS[k].b);
         check64({tag, " data"}, res_data, VECS[k].exp);
         check64({tag, " illegal"}, {63'b0, res_illegal}, {63'b0, VECS[k].ill});
         check64({tag, " R9 valid"}, {63'b0, res_valid}, 64'd1);
      end

      // R9 hold: new inputs without valid leave the result alone
      issue(4'd14, 2'd0, 64'h0F0F_0F0F_0F0F_0F0F, 64'hFFFF_FFFF_0000_0000);
      @(negedge clk);
      op_code  = 4'd15;
      opnd_a   = '1;
      opnd_b   = '1;
      @(negedge clk);
      check64("R9 hold data", res_data, 64'hF0F0_F0F0_0F0F_0F0F);
      check64("R9 hold illegal", {63'b0, res_illegal}, 64'd0);
      check64("R9 idle valid", {63'b0, res_valid}, 64'd0);

      // R9 back-to-back requests, results one cycle apart
      @(negedge clk);
      op_code  = 4'd0;
      lane_sel = 2'd0;
      opnd_a   = 64'h0101_0101_0101_0101;
      opnd_b   = 64'h0101_0101_0101_0101;
      in_valid = 1'b1;
      @(negedge clk);
      check64("R9 b2b first", res_data, 64'h0202_0202_0202_0202);
      op_code  = 4'd6;
      opnd_b   = 64'h0101_0101_0101_0100;
      @(negedge clk);
      in_valid = 1'b0;
      check64("R9 b2b second", res_data, 64'hFFFF_FFFF_FFFF_FF00);
      check64("R9 b2b valid", {63'b0, res_valid}, 64'd1);

      // R10 reset after an illegal result clears everything
      issue(4'd15, 2'd0, 64'h1, 64'h1);
      check64("R8 flag before reset", {63'b0, res_illegal}, 64'd1);
      @(negedge clk);
      rst      = 1'b1;
      in_valid = 1'b1;
      @(negedge clk);
      rst      = 1'b0;
      in_valid = 1'b0;
      check64("R10 mid valid", {63'b0, res_valid}, 64'd0);
      check64("R10 mid illegal", {63'b0, res_illegal}, 64'd0);
      check64("R10 mid data", res_data, 64'd0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule